// File: doc/BRIEF.md
# Inter-Processor Interrupt Doorbell

This block is a small memory-mapped doorbell that any bus master on a shared register port can use to interrupt a host processor. A master first tags the interrupt with one or more of 28 source flags by writing ones into a set register. In the same write it can set a trigger bit, which produces a stretched pulse on a single interrupt output. The host reads the flags to learn who rang the bell, then writes ones to a clear register to acknowledge the sources it has handled.

The output pulse has a fixed shape: four cycles high, then four cycles low. A trigger that arrives while a pulse window is still running is dropped. Any flag bits carried by that same write are still recorded, so a sender loses no source information when its pulse is merged into one already under way. Both registers read back the same flag state. The port is a single-cycle register interface: one address shared by reads and writes, a write enable, write data, and combinational read data.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset all 28 flags are 0, `host_irq_o` is low, and reads of both registers return 0.
- R2: A write to the set register (address 0x0) sets flag n for every data bit n+4 that is 1. Bits that are 0 leave their flags unchanged, so flags accumulate across writes.
- R3: A write to the clear register (address 0x4) clears flag n for every data bit n+4 that is 1. Bits that are 0 leave their flags unchanged. The next read of either register shows the cleared flag as 0.
- R4: Reading address 0x0 or 0x4 returns flag n at bit n+4. Bits 3:0 always read 0, which includes the self-clearing trigger at bit 0 of the set register. Writes to bits 3:1 of the set register and to bits 3:0 of the clear register have no effect.
- R5: A write to the set register with bit 0 equal to 1, when accepted, drives `host_irq_o` high for exactly 4 cycles, beginning in the cycle after the write. It is then low for at least 4 cycles.
- R6: A trigger is accepted only if the write edge falls at least 8 cycles after the previously accepted trigger. Earlier triggers produce no extra pulse. A trigger exactly 8 cycles later is accepted and starts a new high phase at once.
- R7: A set-register write whose trigger is dropped still sets its flags.
- R8: Writes to any address other than 0x0 and 0x4 change neither the flags nor the output, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| addr_i | input | 4 | Byte address for reads and writes |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| host_irq_o | output | 1 | Stretched interrupt pulse toward the host |

## Verification
The bound checker checks on every cycle the flag effects of set and clear writes, flag stability when no register is written, zero reserved read bits, and the pulse shape: no high phase longer or shorter than four cycles, and at least four low cycles before any rise. Only the directed scenarios can show which trigger writes are accepted and which are dropped relative to the window, including the exact eighth-cycle boundary. They also show that a dropped trigger keeps its flags, that unmapped addresses are inert, and the reset read values.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;

    // data bit that carries the pulse request in a set-register write
    localparam int unsigned TRIG_BIT = 0;

    // which register a bus access targets
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/ipi_flag_bank.sv
module ipi_flag_bank #(
    parameter int unsigned NUM_FLAGS = 28
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // clear takes priority over set for the same flag
    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags | set_i) & ~clr_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/ipi_pulse_stretch.sv
module ipi_pulse_stretch #(
    parameter int unsigned HIGH_CYC = 4,
    parameter int unsigned LOW_CYC  = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int unsigned WIN   = HIGH_CYC + LOW_CYC;
    localparam int unsigned CNT_W = $clog2(WIN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } stretch_st_t;

    stretch_st_t st_d, st_q;
    logic        accept;

    // cnt counts down the remaining window; a value of 1 is the last
    // blocked cycle, so a trigger sampled then starts a fresh window
    always_comb begin
        st_d   = st_q;
        accept = trig_i && (st_q.cnt <= CNT_W'(1));
        if (accept) begin
            st_d.cnt = CNT_W'(WIN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        st_d.pulse = (st_d.cnt > CNT_W'(LOW_CYC));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/ipi_reg_decode.sv
module ipi_reg_decode
    import ipi_doorbell_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_FLAGS = 28,
    parameter int unsigned FLAG_LSB  = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h4
) (
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [NUM_FLAGS-1:0] flags_i,
    output logic [NUM_FLAGS-1:0] set_o,
    output logic [NUM_FLAGS-1:0] clr_o,
    output logic                 trig_o,
    output logic [DATA_W-1:0]    rd_data_o
);

    reg_sel_e sel;

    always_comb begin
        if (addr_i == SET_ADDR) begin
            sel = SEL_SET;
        end else if (addr_i == CLR_ADDR) begin
            sel = SEL_CLR;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        set_o  = '0;
        clr_o  = '0;
        trig_o = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_SET: begin
                    set_o  = wr_data_i[FLAG_LSB +: NUM_FLAGS];
                    trig_o = wr_data_i[TRIG_BIT];
                end
                SEL_CLR: clr_o = wr_data_i[FLAG_LSB +: NUM_FLAGS];
                default: ;
            endcase
        end
    end

    // both views place the same flags; the low reserved/trigger bits read 0
    always_comb begin
        rd_data_o = '0;
        if (sel != SEL_NONE) begin
            rd_data_o[FLAG_LSB +: NUM_FLAGS] = flags_i;
        end
    end

endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FLAG_LSB  = 4,
    parameter int unsigned HIGH_CYC  = 4,
    parameter int unsigned LOW_CYC   = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              host_irq_o
);

    localparam int unsigned NUM_FLAGS = DATA_W - FLAG_LSB;

    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] set_mask;
    logic [NUM_FLAGS-1:0] clr_mask;
    logic                 trig;

    ipi_reg_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_FLAGS (NUM_FLAGS),
        .FLAG_LSB  (FLAG_LSB),
        .SET_ADDR  (SET_ADDR),
        .CLR_ADDR  (CLR_ADDR)
    ) u_decode (
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .flags_i   (flags_q),
        .set_o     (set_mask),
        .clr_o     (clr_mask),
        .trig_o    (trig),
        .rd_data_o (rd_data_o)
    );

    ipi_flag_bank #(
        .NUM_FLAGS (NUM_FLAGS)
    ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_mask),
        .clr_i   (clr_mask),
        .flags_o (flags_q)
    );

    ipi_pulse_stretch #(
        .HIGH_CYC (HIGH_CYC),
        .LOW_CYC  (LOW_CYC)
    ) u_stretch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (trig),
        .pulse_o (host_irq_o)
    );

endmodule

// File: rtl/ipi_doorbell_chk.sv
module ipi_doorbell_chk #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned FLAG_LSB  = 4,
    parameter int unsigned HIGH_CYC  = 4,
    parameter int unsigned LOW_CYC   = 4,
    parameter logic [ADDR_W-1:0] SET_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 4'h4
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         wr_en_i,
    input logic [ADDR_W-1:0]            addr_i,
    input logic [DATA_W-1:0]            wr_data_i,
    input logic [DATA_W-1:0]            rd_data_o,
    input logic                         host_irq_o,
    input logic [DATA_W-FLAG_LSB-1:0]   flags_q
);

    localparam int unsigned NF = DATA_W - FLAG_LSB;

    logic [7:0]    hi_run_q;
    logic [7:0]    lo_run_q;
    logic [NF-1:0] wmask;
    logic          hit_set, hit_clr;

    assign wmask   = wr_data_i[FLAG_LSB +: NF];
    assign hit_set = wr_en_i && (addr_i == SET_ADDR);
    assign hit_clr = wr_en_i && (addr_i == CLR_ADDR);

    // run lengths of the output level, counted independently of the RTL
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hi_run_q <= '0;
            lo_run_q <= 8'hff;
        end else begin
            hi_run_q <= host_irq_o ? hi_run_q + 8'd1 : 8'd0;
            lo_run_q <= host_irq_o ? 8'd0 : ((lo_run_q == 8'hff) ? lo_run_q : lo_run_q + 8'd1);
        end
    end

    // R2
    set_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_set |=> ((flags_q & $past(wmask)) == $past(wmask)));

    // R3
    clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_clr |=> ((flags_q & $past(wmask)) == '0));

    // R8
    flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_set || hit_clr) |=> $stable(flags_q));

    // R4
    low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[FLAG_LSB-1:0] == '0);

    // R5
    high_not_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_irq_o |-> (hi_run_q < 8'(HIGH_CYC)));

    // R5
    high_full_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!host_irq_o && hi_run_q != 8'd0) |-> (hi_run_q == 8'(HIGH_CYC)));

    // R6
    low_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_irq_o && hi_run_q == 8'd0) |-> (lo_run_q >= 8'(LOW_CYC)));

endmodule

bind ipi_doorbell ipi_doorbell_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FLAG_LSB (FLAG_LSB),
    .HIGH_CYC (HIGH_CYC),
    .LOW_CYC  (LOW_CYC),
    .SET_ADDR (SET_ADDR),
    .CLR_ADDR (CLR_ADDR)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .host_irq_o (host_irq_o),
    .flags_q    (flags_q)
);

// File: tb/sim_ipi_doorbell.sv
module sim_ipi_doorbell;

    localparam logic [3:0] A_SET = 4'h0;
    localparam logic [3:0] A_CLR = 4'h4;

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        wr_en_i;
    logic [3:0]  addr_i;
    logic [31:0] wr_data_i;
    logic [31:0] rd_data_o;
    logic        host_irq_o;

    int checks = 0;
    int errors = 0;
    logic [27:0] exp_flags;

    always #4 clk_i = ~clk_i;

    ipi_doorbell u0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .host_irq_o (host_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; the write is taken at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr_i    = a;
        wr_data_i = d;
        wr_en_i   = 1'b1;
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i  = a;
        wr_en_i = 1'b0;
        #1;
        d = rd_data_o;
    endtask

    task automatic chk_flags(input string req);
        logic [31:0] v;
        rd(A_SET, v);
        chk({req, " set view"}, v, {exp_flags, 4'h0});
        rd(A_CLR, v);
        chk({req, " clear view"}, v, {exp_flags, 4'h0});
    endtask

    task automatic t_reset();
        rst_ni = 1'b0; wr_en_i = 1'b0; addr_i = '0; wr_data_i = '0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        exp_flags = '0;
        chk("R1 irq low", {31'd0, host_irq_o}, 32'd0);
        chk_flags("R1");
    endtask

    task automatic t_set_accumulate();
        wr(A_SET, 32'h0000_0050);
        exp_flags = 28'h000_0005;
        chk_flags("R2 first set");
        wr(A_SET, 32'h8000_0000);
        exp_flags = 28'h800_0005;
        chk_flags("R2 accumulate");
        wr(A_SET, 32'h0000_0000);
        chk_flags("R2 zero write");
        chk("R2 no pulse without trigger", {31'd0, host_irq_o}, 32'd0);
    endtask

    task automatic t_ack_clear();
        wr(A_CLR, 32'h0000_004F);
        exp_flags = 28'h800_0001;
        chk_flags("R3 clear one flag");
        wr(A_CLR, 32'h0000_0000);
        chk_flags("R3 zero write");
    endtask

    task automatic t_reserved();
        wr(A_SET, 32'h0000_000E);
        chk_flags("R4 reserved set bits");
        chk("R4 no pulse from reserved bits", {31'd0, host_irq_o}, 32'd0);
        wr(A_CLR, 32'h0000_000F);
        chk_flags("R4 reserved clear bits");
    endtask

    task automatic t_other_addr();
        logic [31:0] v;
        wr(4'h8, 32'hFFFF_FFF0);
        chk_flags("R8 unmapped set");
        wr(4'hC, 32'hFFFF_FFF1);
        chk_flags("R8 unmapped clear");
        for (int i = 0; i < 3; i++) begin
            chk("R8 unmapped trigger", {31'd0, host_irq_o}, 32'd0);
            @(negedge clk_i);
        end
        rd(4'h8, v);
        chk("R8 unmapped read", v, 32'd0);
        wr(A_CLR, 32'hFFFF_FFF0);
        exp_flags = '0;
        chk_flags("R3 clear all");
    endtask

    task automatic t_single_pulse();
        logic [31:0] v;
        wr(A_SET, 32'h0000_0001);
        rd(A_SET, v);
        chk("R4 trigger reads 0", v, 32'd0);
        for (int i = 0; i < 10; i++) begin
            chk($sformatf("R5 pulse shape cycle %0d", i), {31'd0, host_irq_o},
                {31'd0, (i < 4)});
            @(negedge clk_i);
        end
    endtask

    task automatic t_dropped();
        wr(A_SET, 32'h0000_0001);
        chk("R6 first pulse", {31'd0, host_irq_o}, 32'd1);
        for (int i = 1; i < 12; i++) begin
            if (i == 1) wr(A_SET, 32'h0000_0001);
            else if (i == 5) wr(A_SET, 32'h0000_0101);
            else if (i == 7) wr(A_SET, 32'h0000_0001);
            else @(negedge clk_i);
            chk($sformatf("R6 dropped trigger cycle %0d", i), {31'd0, host_irq_o},
                {31'd0, (i < 4)});
        end
        exp_flags = 28'h000_0010;
        chk_flags("R7 flags kept on dropped trigger");
    endtask

    task automatic t_boundary();
        wr(A_SET, 32'h0000_0001);
        chk("R6 boundary first", {31'd0, host_irq_o}, 32'd1);
        for (int i = 1; i < 8; i++) begin
            @(negedge clk_i);
            chk($sformatf("R6 boundary window %0d", i), {31'd0, host_irq_o},
                {31'd0, (i < 4)});
        end
        wr(A_SET, 32'h0000_0001);
        for (int i = 0; i < 8; i++) begin
            chk($sformatf("R6 retrigger at window end %0d", i), {31'd0, host_irq_o},
                {31'd0, (i < 4)});
            @(negedge clk_i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_set_accumulate();
        t_ack_clear();
        t_reserved();
        t_other_addr();
        t_single_pulse();
        t_dropped();
        t_boundary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule